// File: doc/BRIEF.md
# Phase-Correct PWM Generator

This block produces a symmetric pulse-width modulated waveform from an up/down counter. The counter starts at zero, climbs one step per enabled tick to a turning value (TOP) fixed by a resolution select, then steps back down to zero and climbs again. The output level changes when the count equals the active compare value. A match on the way up and a match on the way down mirror each other, so the pulse stays centred in every period.

The compare value is double-buffered. A write lands in a staging register and reaches the comparator only when the counter arrives at TOP. This means a period never sees a torn or mid-cycle duty change. A one-cycle pulse marks each period boundary, when the count comes back to zero. The count enable arrives already prescaled from outside. Bus access and interrupt logic sit in the surrounding system.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset `pwm_out` and `period_pulse` are 0 and the counter sits at zero counting up. With `res_sel` = 00 the generator is disabled: the counter is held at zero and `pwm_out` is 0.
- R2: `res_sel` codes 01, 10 and 11 give TOP = 255, 511 and 1023. One full period lasts 2*TOP ticks (510, 1022, 2046). `period_pulse` is high for exactly one cycle, the cycle after a downward step lands on zero.
- R3: On each cycle with `tick` high the counter moves one step: upward until it reaches TOP, then downward until it reaches zero. Cycles with `tick` low leave the counter and output unchanged.
- R4: In mode `out_mode` = 10 (non-inverting) an internal level is cleared when an upward step lands on the active compare value and set when a downward step lands on it. `pwm_out` equals this level, so a compare value C with 0 < C < TOP gives 2*C high ticks per period.
- R5: In mode 11 (inverting) `pwm_out` is the complement of that level. It goes high on an upward match and low on a downward match. Modes 00 and 01 drive `pwm_out` to 0.
- R6: A pulse on `cmp_wr` stores `cmp_data` in a staging register. The active compare value takes the staging contents only on the step that lands on TOP, or on a restart. A write in the same cycle as that step takes effect one period later.
- R7: An active compare value of 0 keeps the internal level at 0 for the whole period. A value of TOP or more keeps it at 1. When the value is loaded at TOP, the level is set to 1 if the loaded value is at least TOP, and to 0 otherwise.
- R8: Any change of `res_sel` restarts the counter at zero counting up, clears the internal level and copies the staging register to the active compare value. The restart happens on the clock edge where the change is seen, whatever the state of `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaled count enable |
| res_sel | input | 2 | Resolution select (00 off, 01/10/11 = 8/9/10 bit) |
| out_mode | input | 2 | Output mode (00/01 off, 10 non-inverting, 11 inverting) |
| cmp_wr | input | 1 | Write strobe for the compare staging register |
| cmp_data | input | 10 | Compare value to stage |
| pwm_out | output | 1 | PWM waveform |
| period_pulse | output | 1 | One-cycle pulse at each period boundary |

## Verification
The hardest case to reach is a compare write that lands in the same cycle as the step onto TOP. In that cycle the old staged value must be promoted and the new one must wait a full period. The stimulus walks writes across a range of cycle offsets over several periods, including runs with a sparse tick, so that some writes hit the turning point exactly. A cycle-by-cycle model decides the outcome of every such write. Resolution changes are also made mid-slope and while a staged value is pending.

// File: rtl/pwm_pkg.sv
// Shared definitions for the phase-correct PWM generator.
// Assumes the counter width is at least 10 so every resolution code fits.
package pwm_pkg;

    typedef enum logic [1:0] {
        OM_OFF     = 2'b00,
        OM_OFF_ALT = 2'b01,
        OM_NONINV  = 2'b10,
        OM_INV     = 2'b11
    } out_mode_e;

    // Turning value for a resolution code: code 1 -> 2^(w-2)-1, etc.
    function automatic int unsigned top_code(input int unsigned w, input logic [1:0] code);
        if (code == 2'b00) return 0;
        return (32'd1 << (w - 3 + int'(code))) - 1;
    endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
// Up/down counter between zero and a resolution-dependent TOP.
// Assumes tick is a single-cycle enable already prescaled outside.
// Exposes the next count and step direction so the compare and output
// stages can act on the same edge as the counter.
module pwm_updown_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       res_sel,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             restart,
    output logic             adv,
    output logic             step_up,
    output logic             hit_top,
    output logic             hit_zero,
    output logic             res_on
);
    logic [1:0] res_q;
    logic       up_q;

    // Decode the turning value and the step conditions
    always_comb begin
        top_val  = CNT_W'(pwm_pkg::top_code(CNT_W, res_q));
        res_on   = (res_q != 2'b00);
        restart  = (res_sel != res_q) || (res_sel == 2'b00);
        adv      = tick && !restart;
        step_up  = up_q;
        nxt_cnt  = up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
        hit_top  = adv && up_q && (nxt_cnt == top_val);
        hit_zero = adv && !up_q && (nxt_cnt == '0);
    end

    // Count state: restart on a resolution change, else step on tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= 2'b00;
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (restart) begin
            res_q <= res_sel;
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (adv) begin
            cnt_q <= nxt_cnt;
            if (hit_top)       up_q <= 1'b0;
            else if (hit_zero) up_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_cmp_buffer.sv
// Double-buffered compare value: writes go to a staging register,
// and the active register copies it only when load is high.
// Assumes load is asserted at TOP or on a restart.
module pwm_cmp_buffer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load,
    output logic [CNT_W-1:0] stage_q,
    output logic [CNT_W-1:0] act_q
);
    // Staging register captures every write
    always_ff @(posedge clk) begin
        if (!rst_n)  stage_q <= '0;
        else if (wr) stage_q <= wr_data;
    end

    // Active register takes the staged value held before this edge
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= stage_q;
    end
endmodule

// File: rtl/pwm_wave_gen.sv
// Output level and period marker for the phase-correct PWM.
// Assumes the counter supplies the next count and step direction for the
// current edge; the level register updates on the same edge as the count.
module pwm_wave_gen #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic             hit_top,
    input  logic             hit_zero,
    input  logic             step_up,
    input  logic             res_on,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] act_cmp,
    input  logic [CNT_W-1:0] stage_cmp,
    input  logic [1:0]       out_mode,
    output logic             pwm_out,
    output logic             period_pulse
);
    import pwm_pkg::*;

    logic lvl_q;

    // Internal level: pinned at the extremes, toggled by matches otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            lvl_q <= 1'b0;
        end else if (adv) begin
            if (hit_top)                 lvl_q <= (stage_cmp >= top_val);
            else if (act_cmp == '0)      lvl_q <= 1'b0;
            else if (act_cmp >= top_val) lvl_q <= 1'b1;
            else if (nxt_cnt == act_cmp) lvl_q <= !step_up;
        end
    end

    // Period marker: one cycle after a downward step reaches zero
    always_ff @(posedge clk) begin
        if (!rst_n) period_pulse <= 1'b0;
        else        period_pulse <= hit_zero;
    end

    // Output polarity selection
    always_comb begin
        unique case (out_mode_e'(out_mode))
            OM_NONINV: pwm_out = res_on && lvl_q;
            OM_INV:    pwm_out = res_on && !lvl_q;
            default:   pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_phase_gen.sv
// Top of the phase-correct PWM generator: counter, buffered compare and
// waveform stage. Assumes tick is prescaled and cmp_wr is a one-cycle strobe.
module pwm_phase_gen #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       res_sel,
    input  logic [1:0]       out_mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    output logic             pwm_out,
    output logic             period_pulse
);
    logic [CNT_W-1:0] cnt_q, top_val, nxt_cnt, stage_q, act_q;
    logic             restart, adv, step_up, hit_top, hit_zero, res_on;

    pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .res_sel(res_sel),
        .cnt_q(cnt_q), .top_val(top_val), .nxt_cnt(nxt_cnt),
        .restart(restart), .adv(adv), .step_up(step_up),
        .hit_top(hit_top), .hit_zero(hit_zero), .res_on(res_on)
    );

    pwm_cmp_buffer #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wr_data(cmp_data),
        .load(hit_top || restart), .stage_q(stage_q), .act_q(act_q)
    );

    pwm_wave_gen #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .restart(restart), .adv(adv),
        .hit_top(hit_top), .hit_zero(hit_zero), .step_up(step_up),
        .res_on(res_on), .nxt_cnt(nxt_cnt), .top_val(top_val),
        .act_cmp(act_q), .stage_cmp(stage_q), .out_mode(out_mode),
        .pwm_out(pwm_out), .period_pulse(period_pulse)
    );
endmodule

// File: rtl/pwm_phase_gen_chk.sv
// Assertion checker for pwm_phase_gen, attached by bind below.
module pwm_phase_gen_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       res_sel,
    input logic [1:0]       out_mode,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] top_val,
    input logic [CNT_W-1:0] act_q,
    input logic             hit_top,
    input logic             restart,
    input logic             res_on,
    input logic             pwm_out,
    input logic             period_pulse
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        res_on |-> cnt_q <= top_val); // R3
    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_on |-> (cnt_q == '0 && !pwm_out)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |=> !period_pulse); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q)); // R3
    AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode[1] == 1'b0) |-> !pwm_out); // R5
    AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_top && !restart) |=> $stable(act_q)); // R6
    AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0 && out_mode == 2'b10) |-> !pwm_out); // R7
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && res_sel != 2'b00 && $stable(res_sel)) |=> cnt_q == '0); // R8
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .res_sel(res_sel),
    .out_mode(out_mode), .cnt_q(cnt_q), .top_val(top_val), .act_q(act_q),
    .hit_top(hit_top), .restart(restart), .res_on(res_on),
    .pwm_out(pwm_out), .period_pulse(period_pulse)
);

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] res_sel = 2'b00;
    logic [1:0] out_mode = 2'b00;
    logic       cmp_wr = 1'b0;
    logic [9:0] cmp_data = '0;
    logic       pwm_out, period_pulse;

    int    n_cmp = 0, n_bad = 0, tick_div = 1;
    string cur_req = "R1";

    always #2 clk = ~clk; // 250 MHz

    pwm_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .res_sel(res_sel),
        .out_mode(out_mode), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .pwm_out(pwm_out), .period_pulse(period_pulse)
    );

    // Behavioural reference model, integer state
    int m_cnt, m_up, m_lvl, m_act, m_buf, m_res, m_pp;
    function automatic int top_of(int r);
        return (r == 0) ? 0 : (1 << (7 + r)) - 1;
    endfunction

    always @(posedge clk) begin
        int old_buf, nc, t, was_up;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_lvl = 0; m_act = 0; m_buf = 0; m_res = 0; m_pp = 0;
        end else begin
            old_buf = m_buf;
            if (cmp_wr) m_buf = int'(cmp_data);
            m_pp = 0;
            if (int'(res_sel) != m_res || res_sel == 2'b00) begin
                m_res = int'(res_sel); m_cnt = 0; m_up = 1; m_lvl = 0; m_act = old_buf;
            end else if (tick) begin
                t = top_of(m_res);
                was_up = m_up;
                nc = m_up ? m_cnt + 1 : m_cnt - 1;
                if (nc == t) begin
                    m_act = old_buf; m_lvl = (old_buf >= t); m_up = 0;
                end else begin
                    if (nc == 0) begin m_up = 1; m_pp = 1; end
                    if (m_act == 0) m_lvl = 0;
                    else if (m_act >= t) m_lvl = 1;
                    else if (nc == m_act) m_lvl = was_up ? 0 : 1;
                end
                m_cnt = nc;
            end
        end
    end

    function automatic logic model_pwm();
        if (m_res == 0) return 1'b0;
        if (out_mode == 2'b10) return m_lvl[0];
        if (out_mode == 2'b11) return !m_lvl[0];
        return 1'b0;
    endfunction

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (pwm_out !== model_pwm() || period_pulse !== m_pp[0]) begin
                n_bad++;
                $display("FAIL %s: pwm_out=%0b period_pulse=%0b expected %0b %0b",
                         cur_req, pwm_out, period_pulse, model_pwm(), m_pp[0]);
            end
        end
    end

    // Tick driver: high on one cycle out of tick_div
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            k = (k + 1) % tick_div;
            tick = (k == 0);
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cmp(input int v);
        @(posedge clk); #1; cmp_wr = 1'b1; cmp_data = 10'(v);
        @(posedge clk); #1; cmp_wr = 1'b0;
    endtask

    task automatic set_res(input int r);
        @(posedge clk); #1; res_sel = 2'(r);
    endtask

    task automatic set_mode(input int m);
        @(posedge clk); #1; out_mode = 2'(m);
    endtask

    // Measure one period from pulse to pulse: length and high cycles
    task automatic measure(output int len, output int hi);
        do @(negedge clk); while (!period_pulse);
        len = 0; hi = 0;
        do begin
            @(negedge clk);
            len++;
            if (pwm_out) hi++;
        end while (!period_pulse);
    endtask

    initial begin
        int len, hi;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset pwm_out", int'(pwm_out), 0);
        check("R1 reset period_pulse", int'(period_pulse), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R1: disabled resolution holds output low
        cur_req = "R1"; set_mode(2); wr_cmp(100);
        repeat (30) @(posedge clk);
        @(negedge clk); check("R1 disabled pwm_out", int'(pwm_out), 0);

        // R2/R4: 8-bit, non-inverting, C=100
        cur_req = "R4"; set_res(1);
        measure(len, hi); measure(len, hi);
        check("R2 period 8-bit", len, 510);
        check("R4 high ticks C=100", hi, 200);

        // R5: inverting and disabled modes
        cur_req = "R5"; set_mode(3);
        measure(len, hi); measure(len, hi);
        check("R5 inverting high ticks", hi, 310);
        set_mode(0); repeat (300) @(posedge clk);
        @(negedge clk); check("R5 mode 00 low", int'(pwm_out), 0);
        set_mode(1); repeat (300) @(posedge clk);
        set_mode(2);

        // R7: compare extremes
        cur_req = "R7"; wr_cmp(0);
        measure(len, hi); measure(len, hi);
        check("R7 compare 0 high ticks", hi, 0);
        wr_cmp(255);
        measure(len, hi); measure(len, hi);
        check("R7 compare TOP high ticks", hi, 510);
        wr_cmp(700);
        measure(len, hi); measure(len, hi);
        check("R7 compare above TOP high ticks", hi, 510);

        // R6: writes swept across offsets, some on the TOP step
        cur_req = "R6";
        for (int i = 0; i < 24; i++) begin
            repeat (i * 43 % 517) @(posedge clk);
            wr_cmp((i * 37) % 260);
        end
        wr_cmp(60);
        measure(len, hi); measure(len, hi);
        check("R6 staged value in force", hi, 120);

        // R3: sparse tick, 9-bit
        cur_req = "R3"; tick_div = 3; set_res(2); wr_cmp(200);
        repeat (4000) @(posedge clk);
        for (int i = 0; i < 10; i++) begin
            repeat (97 + i * 131) @(posedge clk);
            wr_cmp((i * 71) % 520);
        end
        tick_div = 1;

        // R2: 9-bit and 10-bit periods
        cur_req = "R2"; wr_cmp(300);
        measure(len, hi); measure(len, hi);
        check("R2 period 9-bit", len, 1022);
        check("R4 high ticks 9-bit C=300", hi, 600);
        set_res(3);
        measure(len, hi); measure(len, hi);
        check("R2 period 10-bit", len, 2046);

        // R8: resolution changes mid-slope with a pending write
        cur_req = "R8";
        repeat (777) @(posedge clk);
        wr_cmp(90); set_res(1);
        @(negedge clk); check("R8 restart level low", int'(pwm_out), 0);
        measure(len, hi);
        check("R8 first period after restart", len, 510);
        check("R8 staged value copied", hi, 180);
        repeat (123) @(posedge clk);
        set_res(0); repeat (5) @(posedge clk);
        set_res(2); repeat (1500) @(posedge clk);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule